// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces the system reset for a clocked domain. Three conditions hold the reset active: a supply fault, a manual reset request, and an expired watchdog. The supply fault is reported by two digital comparator flags. One flag shows the supply is below the falling threshold. The other shows it is above the rising threshold, which is the falling threshold plus hysteresis. The manual request is an active-low input. The watchdog expires when software stops toggling a kick input. The block drives an active-low reset output and its exact complement as an active-high output.

Every asynchronous input passes through a two-flop synchroniser before it is used. Timing is counted in ticks from a prescaler. The release delay and the watchdog timeout are derived from the clock frequency, the prescaler divide and a profile bit:

| Profile | Release delay | Watchdog timeout |
|---------|---------------|------------------|
| Standard (`FAST_PROFILE = 0`) | 200 ms | 1600 ms |
| Fast (`FAST_PROFILE = 1`) | 25 ms | 200 ms |

A testbench can lower the clock-frequency parameter so that these become short cycle counts. In the description below, RD is the release delay and TO is the watchdog timeout, both in ticks.

Top module: `rst_supervisor`

## Requirements
- R1: A high level on `vmon_low` makes the reset active. The outputs switch 3 clock edges after the input changes. The reset is re-asserted in the same way whenever the supply dips again, including while a release count is running.
- R2: After a supply fault, the release count does not start until `vmon_ok` is high. While both flags are low, the block keeps its present decision: a reset in progress stays active, and a released system stays released.
- R3: Once the last active condition clears, the reset stays active for RD ticks. With one tick per clock, `sys_rst_n` rises RD+2 clock edges after the input change that cleared that condition. A new condition arriving during the count restarts it from zero.
- R4: A rising edge and a falling edge on `wd_kick` each restart the watchdog. Toggling at intervals shorter than TO keeps the reset inactive, even when same-direction edges are further apart than TO.
- R5: If no kick edge arrives for TO ticks, the reset goes active for RD ticks. With one tick per clock, `sys_rst_n` falls TO+4 edges after the last kick change and rises RD edges later. The watchdog then times out again TO+1 edges after the release, unless it is kicked.
- R6: The watchdog is held cleared while the reset is active. Kick edges seen during a reset neither lengthen it nor hold it on.
- R7: While `man_rst_n` is low, the reset is active whatever the supply and watchdog state. `sys_rst_n` falls 3 edges after `man_rst_n` falls and rises RD+2 edges after `man_rst_n` rises.
- R8: `sys_rst` is always the inverse of `sys_rst_n`.
- R9: While `por_n` is low, the reset outputs are active. After `por_n` rises with the supply good, the release count starts from zero, and `sys_rst_n` rises RD+2 edges later.
- R10: `FAST_PROFILE` chooses the delay and timeout pair shown in the table above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| vmon_low | input | 1 | Supply below falling threshold (asynchronous) |
| vmon_ok | input | 1 | Supply above rising threshold (asynchronous) |
| man_rst_n | input | 1 | Manual reset request, active low (asynchronous) |
| wd_kick | input | 1 | Watchdog service input; either edge restarts the watchdog |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |

## Verification
The bench uses one tick per clock. It drives inputs on falling clock edges and samples on falling edges after a counted number of rising edges.

A supply or manual assertion must show on the outputs at the third edge. A release is due at RD+2 edges, made up of two synchroniser stages and RD counting edges. A watchdog expiry is due at TO+4 edges after the last kick change: two synchroniser stages, one edge-detect stage, TO counting edges and one firing stage.

Each due edge is checked from both sides. The bench samples one edge before the edge where the output is due and finds the old value, then samples at that edge and finds the new value. This catches a result that arrives one cycle early or one cycle late.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    // Bundle of the asynchronous pins that cross into the clock domain.
    typedef struct packed {
        logic sup_low;
        logic sup_ok;
        logic mr_n;
        logic wdi;
    } pin_bundle_t;

    // Safe values while power-on reset is applied: supply treated as faulty.
    localparam pin_bundle_t PIN_IDLE = '{sup_low: 1'b1, sup_ok: 1'b0, mr_n: 1'b1, wdi: 1'b0};

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{s1: INIT, s2: INIT};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/rsup_tick.sv
module rsup_tick #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic por_n,
    output logic tick_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // With DIV = 1 the counter stays at zero and every cycle is a tick.
    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
    parameter int TO_TICKS = 1600
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick_i,
    input  logic wdi_i,
    input  logic clr_i,
    output logic fire_o
);

    localparam int CW = $clog2(TO_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TO_TICKS - 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
        logic          fire;
    } wd_t;

    wd_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = wdi_i;
        st_d.fire = 1'b0;
        // Held cleared during reset; either edge direction restarts.
        if (clr_i || (wdi_i != st_q.prev)) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.fire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{prev: 1'b0, cnt: '0, fire: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = st_q.fire;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsup_pkg::*;
#(
    parameter int CLK_FREQ_HZ  = 50_000_000,
    parameter int TICK_DIV     = 50_000,
    parameter bit FAST_PROFILE = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic vmon_low,
    input  logic vmon_ok,
    input  logic man_rst_n,
    input  logic wd_kick,
    output logic sys_rst_n,
    output logic sys_rst
);

    localparam longint TICK_HZ   = longint'(CLK_FREQ_HZ) / longint'(TICK_DIV);
    localparam longint REL_MS    = FAST_PROFILE ? 25 : 200;
    localparam longint TO_MS     = FAST_PROFILE ? 200 : 1600;
    localparam int     REL_TICKS = int'((TICK_HZ * REL_MS) / 1000);
    localparam int     TO_TICKS  = int'((TICK_HZ * TO_MS) / 1000);
    localparam int     RCW       = $clog2(REL_TICKS + 1);
    localparam logic [RCW-1:0] REL_LAST = RCW'(REL_TICKS - 1);

    typedef struct packed {
        logic           fault;
        logic           active;
        logic [RCW-1:0] rel_cnt;
    } sup_t;

    pin_bundle_t raw_pins;
    pin_bundle_t syn_pins;
    logic        low_s;
    logic        ok_s;
    logic        mr_s;
    logic        kick_s;
    logic        tick;
    logic        wd_fire;
    logic        fault_now;
    logic        hold;
    sup_t        st_d, st_q;

    assign raw_pins = '{sup_low: vmon_low, sup_ok: vmon_ok, mr_n: man_rst_n, wdi: wd_kick};

    rsup_sync #(
        .W    ($bits(pin_bundle_t)),
        .INIT (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_i   (raw_pins),
        .q_o   (syn_pins)
    );

    assign low_s  = syn_pins.sup_low;
    assign ok_s   = syn_pins.sup_ok;
    assign mr_s   = syn_pins.mr_n;
    assign kick_s = syn_pins.wdi;

    rsup_tick #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk    (clk),
        .por_n  (por_n),
        .tick_o (tick)
    );

    rsup_wdog #(
        .TO_TICKS (TO_TICKS)
    ) u_wdog (
        .clk    (clk),
        .por_n  (por_n),
        .tick_i (tick),
        .wdi_i  (kick_s),
        .clr_i  (st_q.active),
        .fire_o (wd_fire)
    );

    always_comb begin
        st_d = st_q;
        // Hysteresis: set below the falling threshold, cleared only above the rising one.
        if (low_s) begin
            fault_now = 1'b1;
        end else if (ok_s) begin
            fault_now = 1'b0;
        end else begin
            fault_now = st_q.fault;
        end
        st_d.fault = fault_now;
        hold = fault_now | ~mr_s | wd_fire;

        if (hold) begin
            st_d.active  = 1'b1;
            st_d.rel_cnt = '0;
        end else if (st_q.active && tick) begin
            if (st_q.rel_cnt == REL_LAST) begin
                st_d.active  = 1'b0;
                st_d.rel_cnt = '0;
            end else begin
                st_d.rel_cnt = st_q.rel_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{fault: 1'b1, active: 1'b1, rel_cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_rst_n = ~st_q.active;
    assign sys_rst   = st_q.active;

endmodule

// File: rtl/rsup_checker.sv
module rsup_checker (
    input logic clk,
    input logic por_n,
    input logic low_s,
    input logic ok_s,
    input logic mr_s,
    input logic wd_fire,
    input logic rst_n,
    input logic rst
);

    // R1: a synchronised low-supply flag forces reset on the next edge
    assert_supply_low_R1: assert property (@(posedge clk) disable iff (!por_n)
        low_s |=> !rst_n);

    // R2: after a dip, no release while the rising-threshold flag is low
    assert_hysteresis_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
        ($past(low_s) && !ok_s) |=> !rst_n);

    // R3: a release only follows a cycle with every condition clear
    assert_release_clean_R3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n) |-> ($past(mr_s) && !$past(low_s) && !$past(wd_fire)));

    // R5: watchdog expiry makes the reset active
    assert_expiry_resets_R5: assert property (@(posedge clk) disable iff (!por_n)
        wd_fire |=> !rst_n);

    // R5: expiry is a single-cycle event
    assert_expiry_pulse_R5: assert property (@(posedge clk) disable iff (!por_n)
        wd_fire |=> !wd_fire);

    // R6: no watchdog expiry is produced while reset is active
    assert_no_expiry_in_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> !wd_fire);

    // R7: manual request forces reset on the next edge
    assert_manual_forces_R7: assert property (@(posedge clk) disable iff (!por_n)
        !mr_s |=> !rst_n);

    // R8: the two outputs move together in opposite directions
    assert_outputs_paired_R8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n) |-> $fell(rst));

endmodule

bind rst_supervisor rsup_checker u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .low_s   (low_s),
    .ok_s    (ok_s),
    .mr_s    (mr_s),
    .wd_fire (wd_fire),
    .rst_n   (sys_rst_n),
    .rst     (sys_rst)
);

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int RD         = 25;   // fast profile at one tick per clock
    localparam int TO         = 200;
    localparam int KICK_GAP   = 150;
    localparam int WATCHDOG   = 150_000;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic vmon_low = 1'b0;
    logic vmon_ok = 1'b1;
    logic man_rst_n = 1'b1;
    logic wd_kick = 1'b0;
    logic sys_rst_n;
    logic sys_rst;
    logic kick_en = 1'b0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;

    rst_supervisor #(
        .CLK_FREQ_HZ  (1000),
        .TICK_DIV     (1),
        .FAST_PROFILE (1'b1)
    ) u0 (
        .clk       (clk),
        .por_n     (por_n),
        .vmon_low  (vmon_low),
        .vmon_ok   (vmon_ok),
        .man_rst_n (man_rst_n),
        .wd_kick   (wd_kick),
        .sys_rst_n (sys_rst_n),
        .sys_rst   (sys_rst)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Background service of the watchdog: toggle every KICK_GAP cycles.
    initial begin
        int gap = 0;
        forever begin
            @(negedge clk);
            if (kick_en) begin
                gap++;
                if (gap >= KICK_GAP) begin
                    wd_kick = ~wd_kick;
                    gap = 0;
                end
            end else begin
                gap = 0;
            end
        end
    end

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_rst(input logic exp_n, input string tag);
        n_checks++;
        if (sys_rst_n !== exp_n) begin
            n_fails++;
            $display("FAIL %s: sys_rst_n=%b expected %b", tag, sys_rst_n, exp_n);
        end
        n_checks++;
        if (sys_rst !== ~exp_n) begin
            n_fails++;
            $display("FAIL R8 (%s): sys_rst=%b expected %b", tag, sys_rst, ~exp_n);
        end
    endtask

    task automatic t_power_on;
        wait_edges(3);
        expect_rst(1'b0, "R9 active during por");
        por_n = 1'b1;
        wait_edges(RD + 1);
        expect_rst(1'b0, "R9 R10 still held one edge before release");
        wait_edges(1);
        expect_rst(1'b1, "R3 R9 R10 released after RD+2");
        kick_en = 1'b1;
    endtask

    task automatic t_kick_both_edges;
        for (int k = 0; k < 15; k++) begin
            wait_edges(100);
            expect_rst(1'b1, "R4 kicks on both edges keep reset off");
        end
    endtask

    task automatic t_timeout;
        kick_en = 1'b0;
        wait_edges(4);
        wd_kick = ~wd_kick;
        wait_edges(TO + 3);
        expect_rst(1'b1, "R5 no expiry before TO+4");
        wait_edges(1);
        expect_rst(1'b0, "R5 expiry at TO+4");
        wait_edges(RD - 1);
        expect_rst(1'b0, "R5 reset held for RD");
        wait_edges(1);
        expect_rst(1'b1, "R5 released after RD");
        wait_edges(TO);
        expect_rst(1'b1, "R5 watchdog restarted from zero");
        wait_edges(1);
        expect_rst(1'b0, "R5 second expiry at TO+1 after release");
    endtask

    task automatic t_kick_during_reset;
        for (int j = 0; j < 20; j++) begin
            if (j % 3 == 0) wd_kick = ~wd_kick;
            wait_edges(1);
        end
        expect_rst(1'b0, "R6 kicks during reset keep it active for now");
        wait_edges(4);
        expect_rst(1'b0, "R6 reset still active one edge before RD");
        wait_edges(1);
        expect_rst(1'b1, "R6 reset not lengthened by kicks");
        wait_edges(TO);
        expect_rst(1'b1, "R6 expiry not advanced by kicks during reset");
        wait_edges(1);
        expect_rst(1'b0, "R6 expiry on schedule, kicks during reset ignored");
        kick_en = 1'b1;
        wait_edges(RD);
        expect_rst(1'b1, "R5 release after expiry");
    endtask

    task automatic t_supply_hysteresis;
        vmon_low = 1'b1;
        vmon_ok  = 1'b0;
        wait_edges(2);
        expect_rst(1'b1, "R1 not yet asserted after 2 edges");
        wait_edges(1);
        expect_rst(1'b0, "R1 asserted at edge 3");
        vmon_low = 1'b0;
        wait_edges(100);
        expect_rst(1'b0, "R2 between thresholds keeps reset");
        vmon_ok = 1'b1;
        wait_edges(RD + 1);
        expect_rst(1'b0, "R2 count starts only above rising threshold");
        wait_edges(1);
        expect_rst(1'b1, "R2 R3 released RD+2 after rising flag");
        vmon_ok = 1'b0;
        wait_edges(50);
        expect_rst(1'b1, "R2 between thresholds keeps released state");
        vmon_ok = 1'b1;
    endtask

    task automatic t_supply_redip;
        vmon_low = 1'b1;
        vmon_ok  = 1'b0;
        wait_edges(3);
        expect_rst(1'b0, "R1 dip asserts reset");
        vmon_low = 1'b0;
        vmon_ok  = 1'b1;
        wait_edges(12);
        expect_rst(1'b0, "R3 count in progress");
        vmon_low = 1'b1;
        vmon_ok  = 1'b0;
        wait_edges(3);
        expect_rst(1'b0, "R1 re-dip during count");
        vmon_low = 1'b0;
        vmon_ok  = 1'b1;
        wait_edges(RD + 1);
        expect_rst(1'b0, "R3 count restarted from zero");
        wait_edges(1);
        expect_rst(1'b1, "R3 full delay after re-dip");
    endtask

    task automatic t_manual;
        man_rst_n = 1'b0;
        wait_edges(2);
        expect_rst(1'b1, "R7 not yet asserted after 2 edges");
        wait_edges(1);
        expect_rst(1'b0, "R7 manual asserts at edge 3");
        wait_edges(150);
        expect_rst(1'b0, "R7 held while manual low with supply good");
        man_rst_n = 1'b1;
        wait_edges(RD + 1);
        expect_rst(1'b0, "R7 held one edge before RD+2");
        wait_edges(1);
        expect_rst(1'b1, "R7 released RD+2 after manual high");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", WATCHDOG);
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_power_on();
        t_kick_both_edges();
        t_timeout();
        t_kick_during_reset();
        t_supply_hysteresis();
        t_supply_redip();
        t_manual();
        wait_edges(5);
        finish_run();
    end

endmodule